// File: doc/BRIEF.md
# Modified AES-128 Block Decryption Core

This core turns one 128-bit ciphertext block back into plaintext. The cipher it undoes is a variant of AES-128 with two changes. Each byte substitution is the standard S-box applied three times in a row. The row rotation uses one of two offset patterns, and a mode bit picks which one. The core runs on its own, so a separate encryption engine can work on another block at the same time.

A one-cycle `load_i` pulse starts a run while the core is idle. On that pulse the core captures the ciphertext, the 128-bit cipher key and the mode bit. It then builds all eleven round keys into local storage, one key per clock. After that it whitens the block with the last round key and runs ten inverse rounds, one per clock, taking the keys from last to first. When the plaintext is ready it raises `done_o` and holds it until the next load. The mode bit must be the same one used when the block was encrypted.

Top module: `mdec_core`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and `plain_o` is all zeros until the first run finishes.
- R2: Take a block encrypted under key K with mode 1. Loading its ciphertext with K and mode 1 makes `plain_o` equal the original plaintext once `done_o` is 1.
- R3: The same round trip as R2 holds with mode 0.
- R4: `done_o` rises exactly 21 rising clock edges after the edge that samples `load_i`. This is 2·10+1: ten key-expansion cycles, one whitening cycle and ten round cycles. `done_o` stays 0 in between.
- R5: Once `done_o` is 1, it stays 1 and `plain_o` stays unchanged for as long as `load_i` is 0. A load sampled while idle clears `done_o` at that same edge.
- R6: While a run is in progress, `load_i` pulses and changes on `cipher_i`, `key_i` and `mode_i` are ignored. The result and the 21-edge latency are those of the block loaded first.
- R7: With a mode bit other than the one used to encrypt, the output is exactly the inverse process of R9 carried out with the supplied mode.
- R8: Round key 0 is the cipher key, with word 0 in bits 127:96. Round key i+1 comes from round key i by the AES-128 word recurrence. SubWord uses the forward S-box applied three times, and the round constants are 01,02,04,08,10,20,40,80,1B,36.
- R9: State byte k is bits [127-8k -: 8], in column k/4 and row k%4. The inverse process is: XOR with round key 10, then for keys 9 down to 0 do right-rotate rows, inverse-substitute, add the key, and inverse-mix unless the key is 0. Mode 1 rotates rows 0..3 right by 1,3,0,2 and mode 0 by 2,0,3,1. Inverse substitution is the inverse S-box applied three times. Inverse mixing multiplies each column by 0B·x³+0D·x²+09·x+0E mod x⁴+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start pulse, sampled only while idle |
| mode_i | input | 1 | Rotation pattern select, captured at load |
| cipher_i | input | 128 | Ciphertext block, captured at load |
| key_i | input | 128 | Cipher key, captured at load |
| plain_o | output | 128 | Recovered plaintext, valid while done_o is 1 |
| done_o | output | 1 | Plaintext ready flag |

## Verification
Seeded random plaintext and key pairs are encrypted by a bench model and fed back through the core for both mode values. These runs show that the substitution, rotation, mixing and key order all invert correctly. All-zero and all-one blocks and keys exercise the degenerate substitution inputs and the constant-only key schedule. A block decrypted with the wrong mode is compared against the bench's own inverse model, which separates the two rotation patterns from each other. A load and input change injected mid-run, and input activity after completion, show that captured state and the finished result are protected.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    localparam int unsigned BLK_W = 128;
    localparam int unsigned N_RND = 10;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPAND = 2'd1,
        PH_WHITEN = 2'd2,
        PH_ROUND  = 2'd3
    } phase_e;

    // Multiply by x in GF(2^8) with the AES reduction polynomial.
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_dbl(p);
        end
        return acc;
    endfunction

    // a^254 gives the multiplicative inverse, with 0 mapping to 0.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] s;
        r = 8'h01;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gf_mul(r, s);
            s = gf_mul(s, s);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        logic [15:0] d;
        d = {a, a} << n;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sub_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sub_inv(input logic [7:0] a);
        logic [7:0] v;
        v = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05;
        return gf_inv(v);
    endfunction

    function automatic logic [7:0] sub3_fwd(input logic [7:0] a);
        return sub_fwd(sub_fwd(sub_fwd(a)));
    endfunction

    function automatic logic [7:0] sub3_inv(input logic [7:0] a);
        return sub_inv(sub_inv(sub_inv(a)));
    endfunction

    // Round constant for key index idx (1-based).
    function automatic logic [7:0] rcon(input int idx);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 1; i < int'(N_RND); i++) begin
            if (i < idx) r = gf_dbl(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/mdec_keysched.sv
module mdec_keysched
    import mdec_pkg::*;
#(
    parameter int unsigned NR = N_RND,
    localparam int unsigned CW = $clog2(NR + 1),
    localparam int unsigned WW = BLK_W / 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [CW-1:0]    rd_idx_i,
    output logic [BLK_W-1:0] rd_key_o,
    output logic             last_o
);

    typedef struct packed {
        logic [NR:0][BLK_W-1:0] rk;
        logic [CW-1:0]          cnt;
        logic                   busy;
    } ks_t;

    ks_t ks_d, ks_q;

    logic [CW-1:0]    prev_idx;
    logic [BLK_W-1:0] prev_key;
    logic [WW-1:0]    rot_w;
    logic [WW-1:0]    sub_w;
    logic [WW-1:0]    mix_w;
    logic [WW-1:0]    nw0, nw1, nw2, nw3;

    assign prev_idx = (ks_q.cnt == '0) ? '0 : ks_q.cnt - 1'b1;
    assign prev_key = ks_q.rk[prev_idx];
    assign rot_w    = {prev_key[WW-9:0], prev_key[WW-1 -: 8]};

    for (genvar b = 0; b < 4; b++) begin : g_subw
        assign sub_w[8*b +: 8] = sub3_fwd(rot_w[8*b +: 8]);
    end

    assign mix_w = sub_w ^ {rcon(int'(ks_q.cnt)), {(WW-8){1'b0}}};
    assign nw0   = prev_key[4*WW-1 -: WW] ^ mix_w;
    assign nw1   = prev_key[3*WW-1 -: WW] ^ nw0;
    assign nw2   = prev_key[2*WW-1 -: WW] ^ nw1;
    assign nw3   = prev_key[WW-1:0]       ^ nw2;

    always_comb begin
        ks_d = ks_q;
        if (start_i) begin
            ks_d.rk[0] = key_i;
            ks_d.cnt   = CW'(1);
            ks_d.busy  = 1'b1;
        end else if (ks_q.busy) begin
            ks_d.rk[ks_q.cnt] = {nw0, nw1, nw2, nw3};
            if (ks_q.cnt == CW'(NR)) begin
                ks_d.busy = 1'b0;
            end else begin
                ks_d.cnt = ks_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ks_q <= '0;
        else         ks_q <= ks_d;
    end

    assign rd_key_o = ks_q.rk[rd_idx_i];
    assign last_o   = ks_q.busy && (ks_q.cnt == CW'(NR));

    // R8: round key 0 is the captured cipher key
    a_r8_key0_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (ks_q.rk[0] == $past(key_i)));

    // R4: expansion index stays within 1..NR while active
    a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ks_q.busy |-> (ks_q.cnt >= CW'(1) && ks_q.cnt <= CW'(NR)));

endmodule

// File: rtl/mdec_round.sv
module mdec_round
    import mdec_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    input  logic             mode_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] state_o
);

    logic [BLK_W-1:0] shifted;
    logic [BLK_W-1:0] subbed;
    logic [BLK_W-1:0] keyed;
    logic [BLK_W-1:0] mixed;

    // Right rotation of each row, offsets picked by mode, then substitution.
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int OFF_A = (r == 0) ? 1 : (r == 1) ? 3 : (r == 2) ? 0 : 2;
            localparam int OFF_B = (r == 0) ? 2 : (r == 1) ? 0 : (r == 2) ? 3 : 1;
            localparam int DST   = int'(BLK_W) - 1 - 8 * (4 * c + r);
            localparam int SRC_A = int'(BLK_W) - 1 - 8 * (4 * ((c - OFF_A + 4) % 4) + r);
            localparam int SRC_B = int'(BLK_W) - 1 - 8 * (4 * ((c - OFF_B + 4) % 4) + r);
            assign shifted[DST -: 8] = mode_i ? state_i[SRC_A -: 8] : state_i[SRC_B -: 8];
            assign subbed[DST -: 8]  = sub3_inv(shifted[DST -: 8]);
        end
    end

    assign keyed = subbed ^ rkey_i;

    for (genvar c = 0; c < 4; c++) begin : g_mix
        localparam int TOP = int'(BLK_W) - 1 - 32 * c;
        logic [7:0] a0, a1, a2, a3;
        assign a0 = keyed[TOP      -: 8];
        assign a1 = keyed[TOP - 8  -: 8];
        assign a2 = keyed[TOP - 16 -: 8];
        assign a3 = keyed[TOP - 24 -: 8];
        assign mixed[TOP      -: 8] = gf_mul(a0, 8'h0E) ^ gf_mul(a1, 8'h0B) ^
                                      gf_mul(a2, 8'h0D) ^ gf_mul(a3, 8'h09);
        assign mixed[TOP - 8  -: 8] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0E) ^
                                      gf_mul(a2, 8'h0B) ^ gf_mul(a3, 8'h0D);
        assign mixed[TOP - 16 -: 8] = gf_mul(a0, 8'h0D) ^ gf_mul(a1, 8'h09) ^
                                      gf_mul(a2, 8'h0E) ^ gf_mul(a3, 8'h0B);
        assign mixed[TOP - 24 -: 8] = gf_mul(a0, 8'h0B) ^ gf_mul(a1, 8'h0D) ^
                                      gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0E);
    end

    assign state_o = last_i ? keyed : mixed;

endmodule

// File: rtl/mdec_core.sv
module mdec_core
    import mdec_pkg::*;
#(
    parameter int unsigned NR = N_RND,
    localparam int unsigned CW = $clog2(NR + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             mode_i,
    input  logic [BLK_W-1:0] cipher_i,
    input  logic [BLK_W-1:0] key_i,
    output logic [BLK_W-1:0] plain_o,
    output logic             done_o
);

    typedef struct packed {
        phase_e           ph;
        logic [CW-1:0]    rnd;
        logic [BLK_W-1:0] st;
        logic             mode;
        logic             done;
    } core_t;

    core_t core_d, core_q;

    logic             ks_start;
    logic             ks_last;
    logic [CW-1:0]    ks_idx;
    logic [BLK_W-1:0] ks_key;
    logic [BLK_W-1:0] rnd_out;

    assign ks_start = (core_q.ph == PH_IDLE) && load_i;
    assign ks_idx   = (core_q.ph == PH_WHITEN) ? CW'(NR) : core_q.rnd;

    mdec_keysched #(.NR(NR)) i_keysched (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (ks_start),
        .key_i    (key_i),
        .rd_idx_i (ks_idx),
        .rd_key_o (ks_key),
        .last_o   (ks_last)
    );

    mdec_round i_round (
        .state_i (core_q.st),
        .rkey_i  (ks_key),
        .mode_i  (core_q.mode),
        .last_i  (core_q.rnd == '0),
        .state_o (rnd_out)
    );

    always_comb begin
        core_d = core_q;
        unique case (core_q.ph)
            PH_IDLE: begin
                if (load_i) begin
                    core_d.st   = cipher_i;
                    core_d.mode = mode_i;
                    core_d.done = 1'b0;
                    core_d.ph   = PH_EXPAND;
                end
            end
            PH_EXPAND: begin
                if (ks_last) core_d.ph = PH_WHITEN;
            end
            PH_WHITEN: begin
                core_d.st  = core_q.st ^ ks_key;
                core_d.rnd = CW'(NR - 1);
                core_d.ph  = PH_ROUND;
            end
            PH_ROUND: begin
                core_d.st = rnd_out;
                if (core_q.rnd == '0) begin
                    core_d.ph   = PH_IDLE;
                    core_d.done = 1'b1;
                end else begin
                    core_d.rnd = core_q.rnd - 1'b1;
                end
            end
            default: core_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    assign plain_o = core_q.st;
    assign done_o  = core_q.done;

    // R5: finished result is held while no load arrives
    a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.done && !load_i) |=> (core_q.done && $stable(core_q.st)));

    // R5: a load taken while idle drops the ready flag
    a_r5_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.ph == PH_IDLE && load_i) |=> !core_q.done);

    // R6: captured mode cannot change during a run
    a_r6_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.ph != PH_IDLE) |=> $stable(core_q.mode));

    // R4: ready flag rises only out of the final round
    a_r4_done_from_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_q.done) |-> ($past(core_q.ph) == PH_ROUND && $past(core_q.rnd) == '0));

endmodule

// File: tb/test_mdec_core.sv
module test_mdec_core;

    logic         clk;
    logic         rst_n;
    logic         load;
    logic         mode;
    logic [127:0] cipher;
    logic [127:0] key_in;
    logic [127:0] plain;
    logic         done;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]   sb  [256];
    logic [7:0]   t3  [256];
    logic [7:0]   it3 [256];
    logic [127:0] rkb [11];

    mdec_core i_mdec_core (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .load_i   (load),
        .mode_i   (mode),
        .cipher_i (cipher),
        .key_i    (key_in),
        .plain_o  (plain),
        .done_o   (done)
    );

    initial clk = 1'b0;
    always #10ns clk = ~clk;

    initial begin
        #(20ns * 150000);
        n_errors++;
        $display("FAIL R4 watchdog: actual no finish, expected finish within 150000 cycles");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // ---------------- reference model ----------------
    function automatic logic [7:0] rl(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1B : 8'h00);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    task automatic build_tables();
        logic [7:0] p, q, x;
        p = 8'h01;
        q = 8'h01;
        sb[0] = 8'h63;
        do begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        for (int i = 0; i < 256; i++) t3[i] = sb[sb[sb[i]]];
        for (int i = 0; i < 256; i++) it3[t3[i]] = 8'(i);
    endtask

    function automatic int b_off(input logic md, input int r);
        if (md) return (r == 0) ? 1 : (r == 1) ? 3 : (r == 2) ? 0 : 2;
        return (r == 0) ? 2 : (r == 1) ? 0 : (r == 2) ? 3 : 1;
    endfunction

    function automatic logic [7:0] gb(input logic [127:0] s, input int c, input int r);
        return s[127 - 8 * (4 * c + r) -: 8];
    endfunction

    task automatic expand(input logic [127:0] k);
        logic [31:0] w0, w1, w2, w3, t;
        logic [7:0]  rc;
        rkb[0] = k;
        rc = 8'h01;
        for (int i = 1; i <= 10; i++) begin
            {w0, w1, w2, w3} = rkb[i - 1];
            t = {t3[w3[23:16]], t3[w3[15:8]], t3[w3[7:0]], t3[w3[31:24]]};
            t[31:24] = t[31:24] ^ rc;
            w0 = w0 ^ t;
            w1 = w1 ^ w0;
            w2 = w2 ^ w1;
            w3 = w3 ^ w2;
            rkb[i] = {w0, w1, w2, w3};
            rc = gm(rc, 8'h02);
        end
    endtask

    function automatic logic [127:0] b_enc(input logic [127:0] pt, input logic md);
        logic [127:0] s, u;
        s = pt ^ rkb[0];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int i = 0; i < 16; i++) s[127 - 8 * i -: 8] = t3[s[127 - 8 * i -: 8]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    u[127 - 8 * (4 * c + r) -: 8] = gb(s, (c + b_off(md, r)) % 4, r);
            s = u;
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = gb(s, c, 0); a1 = gb(s, c, 1); a2 = gb(s, c, 2); a3 = gb(s, c, 3);
                    u[127 - 32 * c      -: 8] = gm(a0, 2) ^ gm(a1, 3) ^ a2 ^ a3;
                    u[127 - 32 * c - 8  -: 8] = a0 ^ gm(a1, 2) ^ gm(a2, 3) ^ a3;
                    u[127 - 32 * c - 16 -: 8] = a0 ^ a1 ^ gm(a2, 2) ^ gm(a3, 3);
                    u[127 - 32 * c - 24 -: 8] = gm(a0, 3) ^ a1 ^ a2 ^ gm(a3, 2);
                end
                s = u;
            end
            s = s ^ rkb[rd];
        end
        return s;
    endfunction

    function automatic logic [127:0] b_dec(input logic [127:0] ct, input logic md);
        logic [127:0] s, u;
        s = ct ^ rkb[10];
        for (int rd = 9; rd >= 0; rd--) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    u[127 - 8 * (4 * c + r) -: 8] = gb(s, (c - b_off(md, r) + 4) % 4, r);
            s = u;
            for (int i = 0; i < 16; i++) s[127 - 8 * i -: 8] = it3[s[127 - 8 * i -: 8]];
            s = s ^ rkb[rd];
            if (rd > 0) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = gb(s, c, 0); a1 = gb(s, c, 1); a2 = gb(s, c, 2); a3 = gb(s, c, 3);
                    u[127 - 32 * c      -: 8] = gm(a0, 14) ^ gm(a1, 11) ^ gm(a2, 13) ^ gm(a3, 9);
                    u[127 - 32 * c - 8  -: 8] = gm(a0, 9) ^ gm(a1, 14) ^ gm(a2, 11) ^ gm(a3, 13);
                    u[127 - 32 * c - 16 -: 8] = gm(a0, 13) ^ gm(a1, 9) ^ gm(a2, 14) ^ gm(a3, 11);
                    u[127 - 32 * c - 24 -: 8] = gm(a0, 11) ^ gm(a1, 13) ^ gm(a2, 9) ^ gm(a3, 14);
                end
                s = u;
            end
        end
        return s;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chkint(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Starts at a falling edge; lat counts rising edges after the load edge.
    task automatic run_block(input logic [127:0] ct, input logic [127:0] k, input logic md,
                             input int poke, output logic [127:0] res, output int lat,
                             output logic early_done);
        cipher = ct;
        key_in = k;
        mode   = md;
        load   = 1'b1;
        @(negedge clk);
        load = 1'b0;
        lat = 0;
        early_done = 1'b0;
        while (lat < 100) begin
            if (lat == poke) begin
                load   = 1'b1;
                cipher = ~ct;
                key_in = ~k;
                mode   = ~md;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (done) break;
        end
        load = 1'b0;
        res  = plain;
        if (lat < 21 && done) early_done = 1'b1;
    endtask

    task automatic round_trip(input logic [127:0] pt, input logic [127:0] k, input logic md);
        logic [127:0] ct, res;
        int           lat;
        logic         early;
        expand(k);
        ct = b_enc(pt, md);
        run_block(ct, k, md, -1, res, lat, early);
        if (md) chk128("R2 mode1 round trip", res, pt);
        else    chk128("R3 mode0 round trip", res, pt);
        chkint("R4 latency", lat, 21);
    endtask

    initial begin
        logic [127:0] pt, k, ct, res, hold;
        int           lat;
        logic         early;

        void'($urandom(32'd24680));
        build_tables();
        rst_n  = 1'b0;
        load   = 1'b0;
        mode   = 1'b0;
        cipher = '0;
        key_in = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chkint("R1 done in reset", int'(done), 0);
        chk128("R1 plain in reset", plain, '0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chkint("R1 done after reset", int'(done), 0);
        chk128("R1 plain after reset", plain, '0);

        // Directed corners, both modes (R2, R3, R4, R8)
        for (int m = 1; m >= 0; m--) begin
            round_trip('0, '0, 1'(m));
            round_trip('1, '1, 1'(m));
            round_trip('0, '1, 1'(m));
            round_trip(128'h00112233_44556677_8899AABB_CCDDEEFF,
                       128'h01020304_05060708_090A0B0C_0D0E0F10, 1'(m));
        end

        // Random round trips, both modes
        for (int i = 0; i < 16; i++) begin
            round_trip(rnd128(), rnd128(), 1'b1);
            round_trip(rnd128(), rnd128(), 1'b0);
        end

        // R7 / R9: mismatched mode gives the inverse process with the supplied mode
        for (int m = 0; m < 2; m++) begin
            pt = rnd128();
            k  = rnd128();
            expand(k);
            ct = b_enc(pt, 1'(m));
            run_block(ct, k, ~1'(m), -1, res, lat, early);
            chk128("R7 R9 wrong-mode output", res, b_dec(ct, ~1'(m)));
        end

        // R6: load and input changes during a run are ignored
        for (int p = 3; p <= 15; p += 6) begin
            pt = rnd128();
            k  = rnd128();
            expand(k);
            ct = b_enc(pt, 1'b1);
            run_block(ct, k, 1'b1, p, res, lat, early);
            chk128("R6 busy load ignored result", res, pt);
            chkint("R6 busy load latency", lat, 21);
            chkint("R4 no early done", int'(early), 0);
        end

        // R5: result held while idle with input activity, then load clears done
        hold = plain;
        for (int i = 0; i < 6; i++) begin
            cipher = rnd128();
            key_in = rnd128();
            mode   = ~mode;
            @(negedge clk);
        end
        chkint("R5 done held", int'(done), 1);
        chk128("R5 plain held", plain, hold);
        cipher = rnd128();
        load   = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chkint("R5 load clears done", int'(done), 0);
        repeat (25) @(negedge clk);
        chkint("R5 done after restart", int'(done), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule